// File: doc/BRIEF.md
# Skipped-Cycle Power-Down Sequencer

This block sits beside the cycle-by-cycle enable logic of an ON/OFF switching regulator. On every cycle-start strobe it is told whether that cycle actually switched. When the load becomes very light, the enable logic stops switching for long stretches. The block looks for a specific light-load signature: a run of at least `RUN_LEN` skipped cycles, then exactly one switched cycle, then another `RUN_LEN` skipped cycles. When it sees that signature, it enters a power-down state in which all switching is inhibited.

While powered down, the block waits for a comparator flag reporting that the supply rail has drained to its wake level. It then raises a recharge request and holds it until a second comparator flag reports that the rail is back at its upper regulation level. After that it returns to normal operation and starts a fresh evaluation of the load. If the signature appears again, it powers down again. Otherwise switching simply continues.

A single parameter chooses between the two product variants. One variant uses a skip run of 160 cycles and the other uses 416.

The states are:
- `ST_SKIP_RUN_A`: counting the first skip run.
- `ST_AWAIT_ACTIVE`: the first run is complete and the block waits for the single switched cycle.
- `ST_SKIP_RUN_B`: counting the second skip run.
- `ST_POWERED_DOWN`: switching is inhibited until the rail reaches its wake level.
- `ST_RECHARGE`: the recharge request is held until the rail reaches its upper level.

The transitions are:
- Run-A complete moves the block from `ST_SKIP_RUN_A` to `ST_AWAIT_ACTIVE`.
- The single active cycle moves it from `ST_AWAIT_ACTIVE` to `ST_SKIP_RUN_B`.
- An extra active cycle moves it from `ST_SKIP_RUN_B` back to `ST_SKIP_RUN_A`.
- Run-B complete moves it from `ST_SKIP_RUN_B` to `ST_POWERED_DOWN`.
- Wake moves it from `ST_POWERED_DOWN` to `ST_RECHARGE`.
- Recharged moves it from `ST_RECHARGE` to `ST_SKIP_RUN_A`.
- A switched cycle inside `ST_SKIP_RUN_A` clears the count and keeps the block in that state.

Top module: `skipcyc_pd_seq`

## Requirements
- R1: The skip-run length is 160 strobes when `DEEP_VARIANT` is 0 and 416 strobes when `DEEP_VARIANT` is 1.
- R2: `pd_active` goes high on the clock edge that samples the strobe completing this sequence: at least `RUN_LEN` skipped strobes, exactly one switched strobe, then `RUN_LEN` skipped strobes. It is low before that edge.
- R3: A second switched strobe right after the single active one, or a switched strobe inside the second run, restarts detection from scratch. No power-down follows until a complete new sequence has been seen.
- R4: While `pd_active` is high, `sw_inhibit` is high. Strobes and switched flags have no effect, and the state holds until `rail_low` is seen.
- R5: When `rail_low` is high while powered down, the next clock edge leaves `recharge_req`=1, `pd_active`=0 and `sw_inhibit`=1. This holds, with strobes ignored, until `rail_top` is seen.
- R6: When `rail_top` is high during recharge, the next edge returns the block to normal operation with all three outputs at 0 and detection started fresh. A recurring sequence then powers the block down again.
- R7: The skip counter changes only on edges where `cyc_start` is high. Clock cycles without a strobe do not affect detection, whatever `cyc_fired` shows.
- R8: The skip counter saturates at `RUN_LEN`. A first run longer than `RUN_LEN` still qualifies.
- R9: A synchronous active-high `rst` returns the block to normal operation with all outputs at 0 and the counter cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-clock strobe at the start of each switching cycle |
| cyc_fired | input | 1 | Sampled with `cyc_start`: 1 if that cycle switched, 0 if it was skipped |
| rail_low | input | 1 | Comparator flag: supply rail has fallen to the wake level |
| rail_top | input | 1 | Comparator flag: supply rail has reached the upper regulation level |
| pd_active | output | 1 | High while powered down |
| recharge_req | output | 1 | High while the rail recharge is requested |
| sw_inhibit | output | 1 | High whenever switching must be suppressed |

## Verification
The bench builds its main instance with `RUN_LEN` reduced to 4. At that size, every 12-strobe sequence of switched and skipped cycles can be swept: 4096 sequences, each compared strobe by strobe against a suffix-match model. That sweep covers every placement of stray active cycles, long first runs and doubled active cycles. Two further instances, built with the default parameters and with the deep variant, check that power-down lands on exactly the 160th and the 416th skipped strobe of the second run. Directed sequences on the small instance then walk through wake, recharge and re-entry.

// File: rtl/skipcyc_pd_pkg.sv
package skipcyc_pd_pkg;

    localparam int unsigned SKIP_RUN_STD  = 160;
    localparam int unsigned SKIP_RUN_DEEP = 416;

    typedef enum logic [2:0] {
        ST_SKIP_RUN_A   = 3'd0,
        ST_AWAIT_ACTIVE = 3'd1,
        ST_SKIP_RUN_B   = 3'd2,
        ST_POWERED_DOWN = 3'd3,
        ST_RECHARGE     = 3'd4
    } pd_state_e;

    function automatic int unsigned run_len_for(input bit deep);
        return deep ? SKIP_RUN_DEEP : SKIP_RUN_STD;
    endfunction

endpackage

// File: rtl/skipcyc_run_counter.sv
module skipcyc_run_counter #(
    parameter int unsigned RUN_LEN = 160,
    parameter int unsigned CNT_W   = $clog2(RUN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    output logic [CNT_W-1:0] cnt,
    output logic             at_last
);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(RUN_LEN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RUN_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (step && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_last = (cnt == CNT_LAST);

endmodule

// File: rtl/skipcyc_pattern_fsm.sv
module skipcyc_pattern_fsm
    import skipcyc_pd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cyc_start,
    input  logic      cyc_fired,
    input  logic      rail_low,
    input  logic      rail_top,
    input  logic      at_last,
    output pd_state_e state,
    output logic      cnt_clr,
    output logic      cnt_step
);
    pd_state_e state_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_SKIP_RUN_A;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_clr  = 1'b0;
        cnt_step = 1'b0;
        unique case (state)
            ST_SKIP_RUN_A: begin
                if (cyc_start) begin
                    if (cyc_fired) begin
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_step = 1'b1;
                        if (at_last) begin
                            state_nx = ST_AWAIT_ACTIVE;
                        end
                    end
                end
            end
            ST_AWAIT_ACTIVE: begin
                if (cyc_start) begin
                    if (cyc_fired) begin
                        cnt_clr  = 1'b1;
                        state_nx = ST_SKIP_RUN_B;
                    end else begin
                        cnt_step = 1'b1;
                    end
                end
            end
            ST_SKIP_RUN_B: begin
                if (cyc_start) begin
                    if (cyc_fired) begin
                        cnt_clr  = 1'b1;
                        state_nx = ST_SKIP_RUN_A;
                    end else if (at_last) begin
                        cnt_clr  = 1'b1;
                        state_nx = ST_POWERED_DOWN;
                    end else begin
                        cnt_step = 1'b1;
                    end
                end
            end
            ST_POWERED_DOWN: begin
                if (rail_low) begin
                    state_nx = ST_RECHARGE;
                end
            end
            ST_RECHARGE: begin
                if (rail_top) begin
                    cnt_clr  = 1'b1;
                    state_nx = ST_SKIP_RUN_A;
                end
            end
            default: begin
                cnt_clr  = 1'b1;
                state_nx = ST_SKIP_RUN_A;
            end
        endcase
    end

endmodule

// File: rtl/skipcyc_pd_seq.sv
module skipcyc_pd_seq
    import skipcyc_pd_pkg::*;
#(
    parameter bit          DEEP_VARIANT = 1'b0,
    parameter int unsigned RUN_LEN      = run_len_for(DEEP_VARIANT)
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_start,
    input  logic cyc_fired,
    input  logic rail_low,
    input  logic rail_top,
    output logic pd_active,
    output logic recharge_req,
    output logic sw_inhibit
);
    localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);

    pd_state_e        state;
    logic             cnt_clr;
    logic             cnt_step;
    logic             at_last;
    logic [CNT_W-1:0] run_cnt;

    skipcyc_pattern_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cyc_start (cyc_start),
        .cyc_fired (cyc_fired),
        .rail_low  (rail_low),
        .rail_top  (rail_top),
        .at_last   (at_last),
        .state     (state),
        .cnt_clr   (cnt_clr),
        .cnt_step  (cnt_step)
    );

    skipcyc_run_counter #(
        .RUN_LEN (RUN_LEN),
        .CNT_W   (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (cnt_clr),
        .step    (cnt_step),
        .cnt     (run_cnt),
        .at_last (at_last)
    );

    always_comb begin
        pd_active    = 1'b0;
        recharge_req = 1'b0;
        sw_inhibit   = 1'b0;
        unique case (state)
            ST_SKIP_RUN_A, ST_AWAIT_ACTIVE, ST_SKIP_RUN_B: begin
                sw_inhibit = 1'b0;
            end
            ST_POWERED_DOWN: begin
                pd_active  = 1'b1;
                sw_inhibit = 1'b1;
            end
            ST_RECHARGE: begin
                recharge_req = 1'b1;
                sw_inhibit   = 1'b1;
            end
            default: begin
                sw_inhibit = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/skipcyc_pd_checker.sv
module skipcyc_pd_checker
    import skipcyc_pd_pkg::*;
#(
    parameter int unsigned RUN_LEN = 160,
    parameter int unsigned CNT_W   = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cyc_start,
    input logic             cyc_fired,
    input logic             rail_low,
    input logic             rail_top,
    input logic             pd_active,
    input logic             recharge_req,
    input logic             sw_inhibit,
    input pd_state_e        state,
    input logic [CNT_W-1:0] run_cnt
);
    AST_ENTRY_ON_SKIP: assert property (@(posedge clk) disable iff (rst)
        $rose(pd_active) |-> $past(cyc_start && !cyc_fired)); // R2
    AST_EXTRA_ACTIVE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP_RUN_B && cyc_start && cyc_fired) |=> (state == ST_SKIP_RUN_A && run_cnt == '0)); // R3
    AST_HOLD_DOWN: assert property (@(posedge clk) disable iff (rst)
        (pd_active && !rail_low) |=> (pd_active && sw_inhibit)); // R4
    AST_WAKE_RECHARGE: assert property (@(posedge clk) disable iff (rst)
        (pd_active && rail_low) |=> (recharge_req && !pd_active && sw_inhibit)); // R5
    AST_RECHARGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (recharge_req && !rail_top) |=> recharge_req); // R5
    AST_RECHARGE_DONE: assert property (@(posedge clk) disable iff (rst)
        (recharge_req && rail_top) |=> (!sw_inhibit && run_cnt == '0)); // R6
    AST_STROBE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!cyc_start && !recharge_req) |=> $stable(run_cnt)); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= CNT_W'(RUN_LEN)); // R8
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!pd_active && !recharge_req && !sw_inhibit && run_cnt == '0)); // R9
endmodule

bind skipcyc_pd_seq skipcyc_pd_checker #(
    .RUN_LEN (RUN_LEN),
    .CNT_W   (CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cyc_start    (cyc_start),
    .cyc_fired    (cyc_fired),
    .rail_low     (rail_low),
    .rail_top     (rail_top),
    .pd_active    (pd_active),
    .recharge_req (recharge_req),
    .sw_inhibit   (sw_inhibit),
    .state        (state),
    .run_cnt      (run_cnt)
);

// File: tb/sim_skipcyc_pd_seq.sv
module sim_skipcyc_pd_seq;
    localparam int N  = 4;
    localparam int SL = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cyc_start = 1'b0;
    logic cyc_fired = 1'b0;
    logic rail_low = 1'b0;
    logic rail_top = 1'b0;
    logic pd0, rc0, ih0, pd1, rc1, ih1, pd2, rc2, ih2;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    skipcyc_pd_seq #(.RUN_LEN(N)) u0 (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_fired(cyc_fired),
        .rail_low(rail_low), .rail_top(rail_top),
        .pd_active(pd0), .recharge_req(rc0), .sw_inhibit(ih0));

    skipcyc_pd_seq u1 (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_fired(cyc_fired),
        .rail_low(rail_low), .rail_top(rail_top),
        .pd_active(pd1), .recharge_req(rc1), .sw_inhibit(ih1));

    skipcyc_pd_seq #(.DEEP_VARIANT(1'b1)) u2 (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_fired(cyc_fired),
        .rail_low(rail_low), .rail_top(rail_top),
        .pd_active(pd2), .recharge_req(rc2), .sw_inhibit(ih2));

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 190000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: {pd,rc,inh} actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cyc_start = 1'b0; cyc_fired = 1'b0; rail_low = 1'b0; rail_top = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic strobe(input logic f);
        @(negedge clk);
        cyc_start = 1'b1; cyc_fired = f;
        @(negedge clk);
        cyc_start = 1'b0; cyc_fired = 1'b0;
    endtask

    task automatic skips(input int n);
        for (int i = 0; i < n; i++) strobe(1'b0);
    endtask

    initial begin
        // R9 reset state
        do_reset();
        chk("R9 reset u0", {pd0, rc0, ih0}, 3'b000);
        chk("R9 reset u1", {pd1, rc1, ih1}, 3'b000);

        // Exhaustive sweep of 12-strobe sequences: R2 R3 R8
        for (int p = 0; p < (1 << SL); p++) begin
            logic [SL-1:0] h;
            logic down;
            h = '0;
            down = 1'b0;
            do_reset();
            chk("R9 reset in sweep", {pd0, rc0, ih0}, 3'b000);
            for (int k = 0; k < SL; k++) begin
                logic b;
                b = p[k];
                h[k] = b;
                strobe(b);
                if (!down && k >= 2 * N) begin
                    logic hit;
                    hit = (h[k-N] == 1'b1);
                    for (int j = 0; j < N; j++) begin
                        if (h[k-j] != 1'b0) hit = 1'b0;
                        if (h[k-N-1-j] != 1'b0) hit = 1'b0;
                    end
                    if (hit) down = 1'b1;
                end
                chk("R2 sweep", {pd0, rc0, ih0}, {down, 1'b0, down});
            end
        end

        // R3: extra active inside second run
        do_reset();
        skips(N); strobe(1'b1); skips(N-1); strobe(1'b1); skips(N);
        chk("R3 active inside run", {pd0, rc0, ih0}, 3'b000);
        strobe(1'b1); skips(N);
        chk("R3 fresh pattern after clear", {pd0, rc0, ih0}, 3'b101);

        // R3: two active cycles in a row
        do_reset();
        skips(N); strobe(1'b1); strobe(1'b1); skips(N);
        chk("R3 doubled active", {pd0, rc0, ih0}, 3'b000);

        // R8: long first run
        do_reset();
        skips(3 * N); strobe(1'b1); skips(N-1);
        chk("R8 before last skip", {pd0, rc0, ih0}, 3'b000);
        strobe(1'b0);
        chk("R8 long first run", {pd0, rc0, ih0}, 3'b101);

        // R4: ignore strobes while down
        strobe(1'b1); strobe(1'b1); strobe(1'b0);
        for (int i = 0; i < 6; i++) @(negedge clk);
        chk("R4 stays down", {pd0, rc0, ih0}, 3'b101);

        // R5: wake to recharge
        rail_low = 1'b1;
        @(negedge clk);
        rail_low = 1'b0;
        chk("R5 wake", {pd0, rc0, ih0}, 3'b011);
        strobe(1'b1); strobe(1'b0);
        for (int i = 0; i < 4; i++) @(negedge clk);
        chk("R5 recharge held", {pd0, rc0, ih0}, 3'b011);

        // R6: recharge done, re-evaluate
        rail_top = 1'b1;
        @(negedge clk);
        rail_top = 1'b0;
        chk("R6 resume normal", {pd0, rc0, ih0}, 3'b000);
        skips(N); strobe(1'b1); skips(N);
        chk("R6 re-enter down", {pd0, rc0, ih0}, 3'b101);

        // R6: no recurrence keeps switching
        rail_low = 1'b1; @(negedge clk); rail_low = 1'b0;
        rail_top = 1'b1; @(negedge clk); rail_top = 1'b0;
        for (int i = 0; i < 3 * N; i++) strobe(1'b1);
        chk("R6 normal continues", {pd0, rc0, ih0}, 3'b000);

        // R9: reset while down
        skips(N); strobe(1'b1); skips(N);
        do_reset();
        chk("R9 reset from down", {pd0, rc0, ih0}, 3'b000);

        // R7: non-strobe cycles do not advance or clear
        skips(N); strobe(1'b1); skips(N-2);
        @(negedge clk);
        cyc_fired = 1'b1;
        for (int i = 0; i < 3 * N; i++) @(negedge clk);
        cyc_fired = 1'b0;
        chk("R7 idle cycles no effect", {pd0, rc0, ih0}, 3'b000);
        skips(1);
        chk("R7 one short", {pd0, rc0, ih0}, 3'b000);
        skips(1);
        chk("R7 completes on strobe", {pd0, rc0, ih0}, 3'b101);

        // R1: 160 and 416 run lengths
        do_reset();
        skips(160); strobe(1'b1); skips(159);
        chk("R1 std one short", {pd1, rc1, ih1}, 3'b000);
        strobe(1'b0);
        chk("R1 std 160", {pd1, rc1, ih1}, 3'b101);
        chk("R1 deep not yet", {pd2, rc2, ih2}, 3'b000);
        do_reset();
        skips(416); strobe(1'b1); skips(415);
        chk("R1 deep one short", {pd2, rc2, ih2}, 3'b000);
        strobe(1'b0);
        chk("R1 deep 416", {pd2, rc2, ih2}, 3'b101);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule